// File: doc/BRIEF.md
# Two-Rail Supply Handover Sequencer

This block drives the enables of two supply paths on each of two output rails. Each rail can be fed either from a main source or from a standby regulator. Three active-high control lines select the source: `pwr_good_i`, `run_i` and `mem_keep_i`. The block decodes them into a wanted source for each rail and moves each rail to that source under its own handover rule.

Rail A must never have both of its sources on at once. It switches break-before-make: the outgoing source drops, both enables stay low for a deadtime, and only then does the incoming source turn on. Rail B must never be left without a source while it is powered. It switches make-before-break: the incoming source turns on, both sources stay on for a bounded overlap, and then the outgoing source drops. Both windows are counted in clock cycles. A fault input overrides all sequencing and clears every enable at once.

Top module: `dual_rail_handover`

## Requirements
- R1: When no deadtime is running, rail A enables exactly one source. `a_main_en_o` is high when `pwr_good_i` and `run_i` are both high; otherwise `a_stby_en_o` is high.
- R2: A rail A handover between two sources drops the outgoing enable at the first clock edge after the wanted source changes. Both enables then stay low for exactly DEAD_CYC cycles, and the incoming enable rises at the next edge.
- R3: `a_main_en_o` and `a_stby_en_o` are never high in the same cycle.
- R4: When `mem_keep_i` is low and no overlap is running, both rail B enables are low from the next clock edge.
- R5: When `mem_keep_i` is high and no overlap is running, rail B enables only `b_main_en_o` if `pwr_good_i` and `run_i` are both high, and only `b_stby_en_o` otherwise.
- R6: A rail B handover between two sources raises the incoming enable at the first edge after the wanted source changes. Both enables stay high for exactly the effective overlap, and then the outgoing enable drops.
- R7: The effective overlap is OVL_CYC clamped to the range OVL_MIN to OVL_MAX.
- R8: If the wanted source changes while a deadtime or an overlap is running, that window still runs to its end. The rail then moves to the source wanted at that time, with a fresh window if a handover is still needed.
- R9: While `fault_i` is high, all four enables and `busy_o` are low in that same cycle. The sequencing state is cleared at the next edge.
- R10: During reset all outputs are low. A rail whose sources are all off, after reset or after a fault, turns on its wanted source at the next edge without any window.
- R11: `busy_o` is high exactly while a rail A deadtime or a rail B overlap is running and `fault_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Main supplies good |
| run_i | input | 1 | System running, not in the light sleep state |
| mem_keep_i | input | 1 | Memory rail (rail B) kept powered |
| fault_i | input | 1 | Fault: clears all enables at once |
| a_main_en_o | output | 1 | Rail A main switch enable |
| a_stby_en_o | output | 1 | Rail A standby regulator enable |
| b_main_en_o | output | 1 | Rail B main pass element enable |
| b_stby_en_o | output | 1 | Rail B standby regulator enable |
| busy_o | output | 1 | A deadtime or an overlap is in progress |

## Verification
The bench builds the block with DEAD_CYC = 3, OVL_CYC = 9, OVL_MIN = 2 and OVL_MAX = 5. These values keep both windows short enough for many handovers and for target changes that land inside a window. Because OVL_CYC lies above OVL_MAX, the overlap is clamped to 5 cycles, so the clamp is exercised and not only the plain parameter value. The unequal window lengths also let the two rails finish their windows in different cycles. That separates their contributions to the busy flag.

// File: rtl/handover_pkg.sv
package handover_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_STBY = 2'd2
  } src_e;

  function automatic int clamp_len(input int val, input int lo, input int hi);
    if (val < lo) return lo;
    if (val > hi) return hi;
    return val;
  endfunction

endpackage

// File: rtl/pwr_target_dec.sv
module pwr_target_dec
  import handover_pkg::*;
(
  input  logic pwr_good_i,
  input  logic run_i,
  input  logic mem_keep_i,
  output src_e tgt_a_o,
  output src_e tgt_b_o
);

  logic full_on;

  always_comb begin
    full_on = pwr_good_i & run_i;
    tgt_a_o = full_on ? SRC_MAIN : SRC_STBY;
    if (!mem_keep_i) tgt_b_o = SRC_NONE;
    else             tgt_b_o = full_on ? SRC_MAIN : SRC_STBY;
  end

endmodule

// File: rtl/bbm_switch.sv
module bbm_switch
  import handover_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  src_e tgt_i,
  output logic main_en_o,
  output logic stby_en_o,
  output logic busy_o
);

  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] DEAD_LD = CW'(DEAD_CYC);
  localparam logic [CW-1:0] ONE     = CW'(1);

  src_e          src_q, src_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    src_d  = src_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (fault_i) begin
      src_d  = SRC_NONE;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - ONE;
      if (cnt_q == ONE) src_d = tgt_i;
    end else if (src_q != tgt_i) begin
      if (src_q == SRC_NONE) begin
        src_d = tgt_i;
      end else begin
        src_d  = SRC_NONE;
        cnt_d  = DEAD_LD;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_NONE;
      cnt_q <= '0;
    end else begin
      src_q <= src_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign main_en_o = (src_q == SRC_MAIN) & ~fault_i;
  assign stby_en_o = (src_q == SRC_STBY) & ~fault_i;
  assign busy_o    = (cnt_q != '0) & ~fault_i;

endmodule

// File: rtl/mbb_switch.sv
module mbb_switch
  import handover_pkg::*;
#(
  parameter int OVL_LEN = 6,
  parameter int OVL_MAX = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  src_e tgt_i,
  output logic main_en_o,
  output logic stby_en_o,
  output logic busy_o
);

  localparam int CW = $clog2(OVL_MAX + 1);
  localparam logic [CW-1:0] OVL_LD = CW'(OVL_LEN);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic          m_q, m_d, s_q, s_d;
  logic          in_main_q, in_main_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  src_e          cur;

  always_comb begin
    if (m_q)      cur = SRC_MAIN;
    else if (s_q) cur = SRC_STBY;
    else          cur = SRC_NONE;
  end

  always_comb begin
    m_d       = m_q;
    s_d       = s_q;
    in_main_d = in_main_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    if (fault_i) begin
      m_d    = 1'b0;
      s_d    = 1'b0;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - ONE;
      if (cnt_q == ONE) begin
        if (in_main_q) s_d = 1'b0;
        else           m_d = 1'b0;
      end
    end else if (cur != tgt_i) begin
      if (tgt_i == SRC_NONE) begin
        m_d = 1'b0;
        s_d = 1'b0;
      end else if (cur == SRC_NONE) begin
        m_d = (tgt_i == SRC_MAIN);
        s_d = (tgt_i == SRC_STBY);
      end else begin
        m_d       = 1'b1;
        s_d       = 1'b1;
        in_main_d = (tgt_i == SRC_MAIN);
        cnt_d     = OVL_LD;
        cnt_en    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q       <= 1'b0;
      s_q       <= 1'b0;
      in_main_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      m_q       <= m_d;
      s_q       <= s_d;
      in_main_q <= in_main_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign main_en_o = m_q & ~fault_i;
  assign stby_en_o = s_q & ~fault_i;
  assign busy_o    = (cnt_q != '0) & ~fault_i;

endmodule

// File: rtl/dual_rail_handover.sv
module dual_rail_handover
  import handover_pkg::*;
#(
  parameter int DEAD_CYC = 4,
  parameter int OVL_CYC  = 6,
  parameter int OVL_MIN  = 2,
  parameter int OVL_MAX  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good_i,
  input  logic run_i,
  input  logic mem_keep_i,
  input  logic fault_i,
  output logic a_main_en_o,
  output logic a_stby_en_o,
  output logic b_main_en_o,
  output logic b_stby_en_o,
  output logic busy_o
);

  localparam int OVL_EFF = clamp_len(OVL_CYC, OVL_MIN, OVL_MAX);

  src_e tgt_a, tgt_b;
  logic busy_a, busy_b;

  pwr_target_dec u_dec (
    .pwr_good_i (pwr_good_i),
    .run_i      (run_i),
    .mem_keep_i (mem_keep_i),
    .tgt_a_o    (tgt_a),
    .tgt_b_o    (tgt_b)
  );

  bbm_switch #(.DEAD_CYC(DEAD_CYC)) u_rail_a (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_i   (fault_i),
    .tgt_i     (tgt_a),
    .main_en_o (a_main_en_o),
    .stby_en_o (a_stby_en_o),
    .busy_o    (busy_a)
  );

  mbb_switch #(.OVL_LEN(OVL_EFF), .OVL_MAX(OVL_MAX)) u_rail_b (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_i   (fault_i),
    .tgt_i     (tgt_b),
    .main_en_o (b_main_en_o),
    .stby_en_o (b_stby_en_o),
    .busy_o    (busy_b)
  );

  assign busy_o = busy_a | busy_b;

endmodule

// File: rtl/dual_rail_handover_chk.sv
module dual_rail_handover_chk (
  input logic clk,
  input logic rst_n,
  input logic mem_keep_i,
  input logic fault_i,
  input logic a_main_en_o,
  input logic a_stby_en_o,
  input logic b_main_en_o,
  input logic b_stby_en_o,
  input logic busy_o
);

  assert_a_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_main_en_o && a_stby_en_o));

  assert_a_stby_after_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_stby_en_o) |-> $past(!a_main_en_o));

  assert_a_main_after_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_main_en_o) |-> $past(!a_stby_en_o));

  assert_b_no_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(b_main_en_o) && b_stby_en_o) |-> $past(b_stby_en_o));

  assert_b_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mem_keep_i && !busy_o) |-> (!b_main_en_o && !b_stby_en_o));

  assert_fault_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |-> !(a_main_en_o || a_stby_en_o || b_main_en_o || b_stby_en_o || busy_o));

endmodule

bind dual_rail_handover dual_rail_handover_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_keep_i  (mem_keep_i),
  .fault_i     (fault_i),
  .a_main_en_o (a_main_en_o),
  .a_stby_en_o (a_stby_en_o),
  .b_main_en_o (b_main_en_o),
  .b_stby_en_o (b_stby_en_o),
  .busy_o      (busy_o)
);

// File: tb/dual_rail_handover_tb.sv
`timescale 1ns/1ps
module dual_rail_handover_tb;

  localparam int DEAD = 3;
  localparam int OVLC = 9;
  localparam int OMIN = 2;
  localparam int OMAX = 5;
  localparam int OEFF = 5;  // R7: 9 clamped into [2,5]

  logic clk = 1'b0;
  logic rst_n, pg, run, keep, fault;
  logic a_m, a_s, b_m, b_s, busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_rail_handover #(.DEAD_CYC(DEAD), .OVL_CYC(OVLC), .OVL_MIN(OMIN), .OVL_MAX(OMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good_i(pg), .run_i(run), .mem_keep_i(keep),
    .fault_i(fault), .a_main_en_o(a_m), .a_stby_en_o(a_s), .b_main_en_o(b_m),
    .b_stby_en_o(b_s), .busy_o(busy)
  );

  // behavioural reference: 0 none, 1 main, 2 standby
  int ma_cur = 0, ma_cnt = 0, mb_cur = 0, mb_cnt = 0, mb_in = 0;

  always @(posedge clk or negedge rst_n) begin
    int ta, tb;
    if (!rst_n) begin
      ma_cur = 0; ma_cnt = 0; mb_cur = 0; mb_cnt = 0; mb_in = 0;
    end else if (fault) begin
      ma_cur = 0; ma_cnt = 0; mb_cur = 0; mb_cnt = 0;
    end else begin
      ta = (pg && run) ? 1 : 2;
      tb = !keep ? 0 : ((pg && run) ? 1 : 2);
      if (ma_cnt > 0) begin
        if (ma_cnt == 1) ma_cur = ta;
        ma_cnt--;
      end else if (ma_cur != ta) begin
        if (ma_cur == 0) ma_cur = ta;
        else begin ma_cur = 0; ma_cnt = DEAD; end
      end
      if (mb_cnt > 0) begin
        if (mb_cnt == 1) mb_cur = mb_in;
        mb_cnt--;
      end else if (mb_cur != tb) begin
        if (tb == 0 || mb_cur == 0) mb_cur = tb;
        else begin mb_cur = 3; mb_in = tb; mb_cnt = OEFF; end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (!done) begin
      int ea, eb, eby;
      ea  = fault ? 0 : ma_cur;
      eb  = fault ? 0 : mb_cur;
      eby = (!fault && (ma_cnt > 0 || mb_cnt > 0)) ? 1 : 0;
      chk("R2 rail A enables", {a_s, a_m}, ea);
      chk("R6 rail B enables", {b_s, b_m}, eb);
      chk("R11 busy", busy, eby);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic p, input logic r, input logic k);
    pg = p; run = r; keep = k;
  endtask

  // count window lengths over n cycles after a change
  task automatic measure(input int n, output int a_gap, output int b_both, output int a_both);
    a_gap = 0; b_both = 0; a_both = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      if (!a_m && !a_s) a_gap++;
      if (a_m && a_s) a_both++;
      if (b_m && b_s) b_both++;
    end
  endtask

  initial begin
    #(5ns * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int g, bb, ab;
    logic [15:0] lf;
    rst_n = 1'b0; fault = 1'b0; drive(0, 0, 0);
    cyc(3); #1;
    chk("R10 reset outputs", {a_m, a_s, b_m, b_s, busy}, 0);

    drive(1, 1, 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 rail A on after reset", {a_s, a_m}, 1);
    chk("R5 rail B main after reset", {b_s, b_m}, 1);

    // full on -> light sleep
    @(negedge clk); drive(1, 0, 1);
    measure(12, g, bb, ab);
    chk("R2 deadtime length", g, DEAD);
    chk("R7 clamped overlap", bb, OEFF);
    chk("R3 rail A exclusive", ab, 0);
    chk("R1 rail A standby", {a_s, a_m}, 2);
    chk("R5 rail B standby", {b_s, b_m}, 2);

    // back to full on
    @(negedge clk); drive(1, 1, 1);
    measure(12, g, bb, ab);
    chk("R2 deadtime length back", g, DEAD);
    chk("R6 overlap length back", bb, OEFF);
    chk("R1 rail A main", {a_s, a_m}, 1);

    // deep sleep: rail B off
    @(negedge clk); drive(0, 0, 0);
    cyc(8); #1;
    chk("R4 rail B off", {b_s, b_m}, 0);
    chk("R1 rail A standby deep", {a_s, a_m}, 2);

    // blocked light-sleep code: rail B comes on from standby
    @(negedge clk); drive(0, 0, 1);
    @(negedge clk); #1;
    chk("R5 rail B standby from off", {b_s, b_m}, 2);
    chk("R10 no window from off", busy, 0);

    // mid-sequence change
    drive(1, 1, 1); cyc(12);
    @(negedge clk); drive(1, 0, 1);
    @(negedge clk); drive(1, 1, 1);
    ab = 0;
    for (int i = 0; i < DEAD + 1; i++) begin
      #1; if (a_s) ab++;
      @(negedge clk);
    end
    chk("R8 rail A no stby after revert", ab, 0);
    #1; chk("R8 rail A main after window", {a_s, a_m}, 1);
    cyc(2 * OEFF + 4); #1;
    chk("R8 rail B back on main", {b_s, b_m}, 1);

    // fault in steady state
    @(negedge clk); fault = 1'b1; #1;
    chk("R9 fault clears now", {a_m, a_s, b_m, b_s, busy}, 0);
    cyc(3); #1;
    chk("R9 fault held", {a_m, a_s, b_m, b_s}, 0);
    @(negedge clk); fault = 1'b0;
    @(negedge clk); #1;
    chk("R10 direct on after fault", {b_s, b_m, a_s, a_m}, 4'b0101);

    // fault inside a deadtime
    @(negedge clk); drive(0, 1, 1);
    @(negedge clk); #1;
    chk("R11 busy in window", busy, 1);
    @(negedge clk); fault = 1'b1; #1;
    chk("R9 fault in window", {a_m, a_s, b_m, b_s, busy}, 0);
    @(negedge clk); fault = 1'b0;
    cyc(2); #1;
    chk("R3 stby direct after fault", {a_s, a_m}, 2);

    // pseudo-random activity, checked by the model every cycle
    lf = 16'hACE1;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[3:0] == 4'd0) drive(lf[5], lf[6], lf[7]);
      fault = (lf[11:4] == 8'hFF);
    end
    fault = 1'b0;
    cyc(20);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule